// File: doc/BRIEF.md
# Cache-Block Operation Decode and Permission Unit

This unit sits next to an instruction decoder. On each strobed 32-bit instruction word it determines whether the word is one of the four cache-block operations (invalidate, clean, flush, zero), a quad-width load that shares their encoding space, or a prefetch hint carried by the immediate-OR encoding. For a recognised cache-block operation it also decides, from the privilege level, the virtualisation flag and three environment-configuration enable vectors, whether the operation is accepted, raises an illegal-instruction exception or raises a virtual-instruction exception.

All results are registered one clock after the input strobe. The unit does no address translation, performs no cache action and does not enter a trap. It only reports the operation kind, the source register index and a cause code, so the pipeline can act on them.

Each enable vector (`menv_en`, `henv_en`, `senv_en`) is three bits wide: bit 0 enables clean and flush, bit 1 enables invalidate, and bit 2 enables zero. Privilege is encoded as 0 for user, 1 for supervisor and 3 for machine. A privilege is treated as below hypervisor level when its value is less than 2.

Top module: `cbo_gate`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_quad` and `out_hint` are low after that edge.
- R2: A word is a cache-block operation when all of these hold: opcode bits [6:0] are 0001111, bits [14:12] are 010, bits [11:7] are 0 and bits [31:25] are 0. Bits [24:20] select the operation: 00000 is invalidate (`out_kind` 0), 00001 is clean (1), 00010 is flush (2), and 00100 is zero (3). One cycle after `in_valid` such a word gives `out_valid`=1, `out_kind` as listed, and `out_rs1` equal to bits [19:15].
- R3: Any other word with opcode 0001111 and bits [14:12]=010 gives `out_quad`=1 and `out_valid`=0.
- R4: With `ext_mgmt_on`=0, invalidate, clean and flush words are treated as quad loads (R3). With `ext_zero_on`=0, the zero word is treated the same way.
- R5: The enable bit used for a check is bit 0 for clean and flush, bit 1 for invalidate, and bit 2 for zero. The same bit index is used in all three enable vectors.
- R6: When `virt_on`=1, a virtual-instruction fault (`out_cause`=2) is raised in either of two cases: privilege is below 2 and the `henv_en` bit is 0, or privilege is 0 and the `senv_en` bit is 0.
- R7: Otherwise, an illegal-instruction fault (`out_cause`=1) is raised in either of two cases: privilege is below 3 and the `menv_en` bit is 0, or privilege is 0 and the `senv_en` bit is 0. If neither fault applies, `out_cause` is 0.
- R8: When the conditions of R6 and R7 both hold, only `out_cause`=2 is reported.
- R9: A word with opcode 0010011, bits [14:12]=110 and bits [11:7]=0 gives `out_hint`=1, `out_valid`=0 and `out_cause`=0, whatever the enable bits are.
- R10: A cycle without `in_valid` gives `out_valid`, `out_quad` and `out_hint` all 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word strobe |
| in_instr | input | 32 | Instruction word |
| priv | input | 2 | Privilege level (0 user, 1 supervisor, 3 machine) |
| virt_on | input | 1 | Virtualisation active |
| menv_en | input | 3 | Machine-level enable vector |
| henv_en | input | 3 | Hypervisor-level enable vector |
| senv_en | input | 3 | Supervisor-level enable vector |
| ext_mgmt_on | input | 1 | Block-management operations implemented |
| ext_zero_on | input | 1 | Block-zero operation implemented |
| out_valid | output | 1 | Cache-block operation recognised |
| out_kind | output | 2 | Operation kind |
| out_rs1 | output | 5 | Source register index |
| out_cause | output | 2 | 0 accept, 1 illegal, 2 virtual |
| out_quad | output | 1 | Word decodes as the quad load |
| out_hint | output | 1 | Word is a prefetch hint (no-op) |

## Verification
Every result comes from a single register stage, so it is due exactly one rising edge after the strobed word. Each scenario task drives its inputs on a falling edge, holds `in_valid` across one rising edge, and samples all outputs at the following falling edge. That falling edge is the midpoint of the cycle in which the registered result is stable, and it comes before the next word is driven. The idle check drops `in_valid` on the same falling edge and reads the outputs one edge later.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
    localparam int INSN_W = 32;
    localparam int REG_W  = 5;
    localparam int PRIV_W = 2;
    localparam int EN_W   = 3;

    localparam logic [6:0] OPC_MISCMEM = 7'b0001111;
    localparam logic [6:0] OPC_OPIMM   = 7'b0010011;
    localparam logic [2:0] F3_CBO      = 3'b010;
    localparam logic [2:0] F3_ORI      = 3'b110;

    localparam logic [PRIV_W-1:0] PRV_U = 2'd0;
    localparam logic [PRIV_W-1:0] PRV_H = 2'd2;
    localparam logic [PRIV_W-1:0] PRV_M = 2'd3;

    localparam int EN_CF = 0;
    localparam int EN_IV = 1;
    localparam int EN_ZR = 2;

    typedef enum logic [1:0] {
        K_INVAL = 2'd0,
        K_CLEAN = 2'd1,
        K_FLUSH = 2'd2,
        K_ZERO  = 2'd3
    } kind_t;

    typedef enum logic [1:0] {
        C_NONE  = 2'd0,
        C_ILL   = 2'd1,
        C_VIRT  = 2'd2
    } cause_t;

    typedef struct packed {
        logic             vld;
        kind_t            kind;
        logic [REG_W-1:0] rs1;
        cause_t           cause;
        logic             quad;
        logic             hint;
    } res_t;
endpackage

// File: rtl/cbo_match.sv
module cbo_match
    import cbo_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    input  logic              mgmt_on,
    input  logic              zero_on,
    output logic              hit,
    output kind_t             kind,
    output logic              quad,
    output logic              hint
);
    logic space;
    logic shape;
    logic [4:0] sel;

    always_comb begin
        space = (instr[6:0] == OPC_MISCMEM) && (instr[14:12] == F3_CBO);
        shape = (instr[11:7] == 5'd0) && (instr[31:25] == 7'd0);
        sel   = instr[24:20];
        hit   = 1'b0;
        kind  = K_INVAL;
        if (space && shape) begin
            unique case (sel)
                5'b00000: begin hit = mgmt_on; kind = K_INVAL; end
                5'b00001: begin hit = mgmt_on; kind = K_CLEAN; end
                5'b00010: begin hit = mgmt_on; kind = K_FLUSH; end
                5'b00100: begin hit = zero_on; kind = K_ZERO;  end
                default:  begin hit = 1'b0;    kind = K_INVAL; end
            endcase
        end
        quad = space && !hit;
        hint = (instr[6:0] == OPC_OPIMM) && (instr[14:12] == F3_ORI)
             && (instr[11:7] == 5'd0);
    end
endmodule

// File: rtl/cbo_perm.sv
module cbo_perm
    import cbo_pkg::*;
(
    input  kind_t             kind,
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt_on,
    input  logic [EN_W-1:0]   menv_en,
    input  logic [EN_W-1:0]   henv_en,
    input  logic [EN_W-1:0]   senv_en,
    output cause_t            cause
);
    int unsigned idx;
    logic m_b, h_b, s_b;
    logic v_flt, i_flt;

    always_comb begin
        unique case (kind)
            K_INVAL: idx = EN_IV;
            K_ZERO:  idx = EN_ZR;
            default: idx = EN_CF;
        endcase
        m_b = menv_en[idx];
        h_b = henv_en[idx];
        s_b = senv_en[idx];
        v_flt = virt_on && (((priv < PRV_H) && !h_b) || ((priv == PRV_U) && !s_b));
        i_flt = ((priv < PRV_M) && !m_b) || ((priv == PRV_U) && !s_b);
        if (v_flt)      cause = C_VIRT;
        else if (i_flt) cause = C_ILL;
        else            cause = C_NONE;
    end
endmodule

// File: rtl/cbo_gate.sv
module cbo_gate
    import cbo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_instr,
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt_on,
    input  logic [EN_W-1:0]   menv_en,
    input  logic [EN_W-1:0]   henv_en,
    input  logic [EN_W-1:0]   senv_en,
    input  logic              ext_mgmt_on,
    input  logic              ext_zero_on,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [REG_W-1:0]  out_rs1,
    output logic [1:0]        out_cause,
    output logic              out_quad,
    output logic              out_hint
);
    logic   m_hit, m_quad, m_hint;
    kind_t  m_kind;
    cause_t p_cause;
    res_t   res_d, res_q;

    cbo_match u_match (
        .instr   (in_instr),
        .mgmt_on (ext_mgmt_on),
        .zero_on (ext_zero_on),
        .hit     (m_hit),
        .kind    (m_kind),
        .quad    (m_quad),
        .hint    (m_hint)
    );

    cbo_perm u_perm (
        .kind    (m_kind),
        .priv    (priv),
        .virt_on (virt_on),
        .menv_en (menv_en),
        .henv_en (henv_en),
        .senv_en (senv_en),
        .cause   (p_cause)
    );

    always_comb begin
        res_d       = res_q;
        res_d.vld   = in_valid && m_hit;
        res_d.quad  = in_valid && m_quad;
        res_d.hint  = in_valid && m_hint;
        res_d.cause = C_NONE;
        if (in_valid && m_hit) begin
            res_d.kind  = m_kind;
            res_d.rs1   = in_instr[19:15];
            res_d.cause = p_cause;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '{vld: 1'b0, kind: K_INVAL, rs1: '0, cause: C_NONE,
                       quad: 1'b0, hint: 1'b0};
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign out_kind  = res_q.kind;
    assign out_rs1   = res_q.rs1;
    assign out_cause = res_q.cause;
    assign out_quad  = res_q.quad;
    assign out_hint  = res_q.hint;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_quad && !out_hint));

    a_r3_quad_excludes_op: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_quad));

    a_r6_virt_needs_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && m_hit && !virt_on) |=> (out_cause != C_VIRT));

    a_r7_machine_accepts: assert property (@(posedge clk) disable iff (rst)
        (in_valid && m_hit && priv == PRV_M && !virt_on) |=> (out_cause == C_NONE));

    a_r9_hint_quiet: assert property (@(posedge clk) disable iff (rst)
        out_hint |-> (!out_valid && out_cause == C_NONE));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_quad && !out_hint));
endmodule

// File: tb/cbo_gate_tb.sv
module cbo_gate_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [1:0]  priv = 2'd3;
    logic        virt_on = 1'b0;
    logic [2:0]  menv_en = 3'b111, henv_en = 3'b111, senv_en = 3'b111;
    logic        ext_mgmt_on = 1'b1, ext_zero_on = 1'b1;
    logic        out_valid, out_quad, out_hint;
    logic [1:0]  out_kind, out_cause;
    logic [4:0]  out_rs1;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbo_gate u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .priv(priv), .virt_on(virt_on), .menv_en(menv_en), .henv_en(henv_en),
        .senv_en(senv_en), .ext_mgmt_on(ext_mgmt_on), .ext_zero_on(ext_zero_on),
        .out_valid(out_valid), .out_kind(out_kind), .out_rs1(out_rs1),
        .out_cause(out_cause), .out_quad(out_quad), .out_hint(out_hint)
    );

    function automatic logic [31:0] cbo_word(input logic [4:0] sel, input logic [4:0] rs1);
        return {7'd0, sel, rs1, 3'b010, 5'd0, 7'b0001111};
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [1:0] p, input logic v,
                         input logic [2:0] m, input logic [2:0] h, input logic [2:0] s);
        in_instr = w; priv = p; virt_on = v;
        menv_en = m; henv_en = h; senv_en = s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "valid", out_valid, 0);
        chk("R1", "quad", out_quad, 0);
        chk("R1", "hint", out_hint, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_decode;
        apply(cbo_word(5'b00000, 5'd7), 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R2", "inval valid", out_valid, 1);
        chk("R2", "inval kind", out_kind, 0);
        chk("R2", "inval rs1", out_rs1, 7);
        chk("R2", "inval cause", out_cause, 0);
        apply(cbo_word(5'b00001, 5'd31), 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R2", "clean kind", out_kind, 1);
        chk("R2", "clean rs1", out_rs1, 31);
        apply(cbo_word(5'b00010, 5'd0), 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R2", "flush kind", out_kind, 2);
        chk("R2", "flush rs1", out_rs1, 0);
        apply(cbo_word(5'b00100, 5'd12), 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R2", "zero valid", out_valid, 1);
        chk("R2", "zero kind", out_kind, 3);
        chk("R2", "zero quad", out_quad, 0);
    endtask

    task automatic t_overlap;
        apply(cbo_word(5'b00001, 5'd3) | 32'h0000_0080, 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R3", "rd!=0 valid", out_valid, 0);
        chk("R3", "rd!=0 quad", out_quad, 1);
        apply(cbo_word(5'b00011, 5'd3), 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R3", "sel 3 valid", out_valid, 0);
        chk("R3", "sel 3 quad", out_quad, 1);
        apply(cbo_word(5'b00000, 5'd3) | 32'h0200_0000, 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R3", "top bits quad", out_quad, 1);
        chk("R3", "top bits valid", out_valid, 0);
    endtask

    task automatic t_ext;
        ext_mgmt_on = 1'b0;
        apply(cbo_word(5'b00001, 5'd4), 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R4", "mgmt off valid", out_valid, 0);
        chk("R4", "mgmt off quad", out_quad, 1);
        apply(cbo_word(5'b00100, 5'd4), 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R4", "mgmt off zero ok", out_valid, 1);
        ext_mgmt_on = 1'b1;
        ext_zero_on = 1'b0;
        apply(cbo_word(5'b00100, 5'd4), 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R4", "zero off valid", out_valid, 0);
        chk("R4", "zero off quad", out_quad, 1);
        apply(cbo_word(5'b00000, 5'd4), 2'd3, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R4", "zero off inval ok", out_valid, 1);
        ext_zero_on = 1'b1;
    endtask

    task automatic t_envbits;
        apply(cbo_word(5'b00001, 5'd1), 2'd1, 1'b0, 3'b110, 3'b111, 3'b111);
        chk("R5", "clean bit0 clear", out_cause, 1);
        apply(cbo_word(5'b00010, 5'd1), 2'd1, 1'b0, 3'b110, 3'b111, 3'b111);
        chk("R5", "flush bit0 clear", out_cause, 1);
        apply(cbo_word(5'b00000, 5'd1), 2'd1, 1'b0, 3'b110, 3'b111, 3'b111);
        chk("R5", "inval ignores bit0", out_cause, 0);
        apply(cbo_word(5'b00000, 5'd1), 2'd1, 1'b0, 3'b101, 3'b111, 3'b111);
        chk("R5", "inval bit1 clear", out_cause, 1);
        apply(cbo_word(5'b00100, 5'd1), 2'd1, 1'b0, 3'b101, 3'b111, 3'b111);
        chk("R5", "zero ignores bit1", out_cause, 0);
        apply(cbo_word(5'b00100, 5'd1), 2'd1, 1'b0, 3'b011, 3'b111, 3'b111);
        chk("R5", "zero bit2 clear", out_cause, 1);
    endtask

    task automatic t_illegal;
        apply(cbo_word(5'b00001, 5'd2), 2'd0, 1'b0, 3'b111, 3'b111, 3'b000);
        chk("R7", "user senv clear", out_cause, 1);
        apply(cbo_word(5'b00001, 5'd2), 2'd1, 1'b0, 3'b111, 3'b111, 3'b000);
        chk("R7", "super ignores senv", out_cause, 0);
        apply(cbo_word(5'b00001, 5'd2), 2'd3, 1'b0, 3'b000, 3'b000, 3'b000);
        chk("R7", "machine always ok", out_cause, 0);
        apply(cbo_word(5'b00001, 5'd2), 2'd0, 1'b0, 3'b110, 3'b111, 3'b111);
        chk("R7", "user menv clear", out_cause, 1);
        apply(cbo_word(5'b00001, 5'd2), 2'd1, 1'b0, 3'b111, 3'b000, 3'b111);
        chk("R6", "henv ignored without virt", out_cause, 0);
    endtask

    task automatic t_virt;
        apply(cbo_word(5'b00000, 5'd9), 2'd1, 1'b1, 3'b111, 3'b000, 3'b111);
        chk("R6", "vs henv clear", out_cause, 2);
        apply(cbo_word(5'b00000, 5'd9), 2'd0, 1'b1, 3'b111, 3'b111, 3'b000);
        chk("R6", "vu senv clear", out_cause, 2);
        apply(cbo_word(5'b00000, 5'd9), 2'd1, 1'b1, 3'b111, 3'b111, 3'b000);
        chk("R6", "vs ignores senv", out_cause, 0);
        apply(cbo_word(5'b00000, 5'd9), 2'd1, 1'b1, 3'b000, 3'b111, 3'b111);
        chk("R7", "vs menv clear illegal", out_cause, 1);
        apply(cbo_word(5'b00000, 5'd9), 2'd0, 1'b1, 3'b111, 3'b111, 3'b111);
        chk("R6", "vu all set", out_cause, 0);
    endtask

    task automatic t_both;
        apply(cbo_word(5'b00100, 5'd5), 2'd1, 1'b1, 3'b000, 3'b000, 3'b111);
        chk("R8", "virt over illegal", out_cause, 2);
        apply(cbo_word(5'b00100, 5'd5), 2'd0, 1'b1, 3'b111, 3'b111, 3'b000);
        chk("R8", "senv both paths", out_cause, 2);
    endtask

    task automatic t_hint;
        apply({12'h013, 5'd6, 3'b110, 5'd0, 7'b0010011}, 2'd0, 1'b1, 3'b000, 3'b000, 3'b000);
        chk("R9", "hint flag", out_hint, 1);
        chk("R9", "hint valid", out_valid, 0);
        chk("R9", "hint cause", out_cause, 0);
        apply({12'h013, 5'd6, 3'b110, 5'd3, 7'b0010011}, 2'd0, 1'b0, 3'b111, 3'b111, 3'b111);
        chk("R9", "ori rd!=0 not hint", out_hint, 0);
    endtask

    task automatic t_idle;
        in_instr = cbo_word(5'b00000, 5'd1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10", "idle valid", out_valid, 0);
        chk("R10", "idle quad", out_quad, 0);
        chk("R10", "idle hint", out_hint, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_decode();
        t_overlap();
        t_ext();
        t_envbits();
        t_illegal();
        t_virt();
        t_both();
        t_hint();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule